// File: doc/BRIEF.md
# Prescaled Interrupt Timer

This block is one counting timer with three registers on a small word bus: the count value, a compare value, and a control/status word. The counter advances on ticks taken from either a system tick strobe or an external event strobe. Those ticks pass through a power-of-two divider first. The counter width is fixed at elaboration time, either 16 or 32 bits.

When the count reaches the compare value, or wraps past its all-ones value, the block records the event in sticky status bits. If the matching interrupt enable is set, it also raises an interrupt request. The request can be a single-clock pulse or a level that flips on each event. It can fire on every event or only on the first event after the control word is written.

Writing the control word restarts the unit. One clock later the count and the divider are both zero. A gate input can freeze counting.

Top module: `prescaled_irq_timer`

## Requirements
- R1: The count is 16 bits wide when parameter WIDE is 0 and 32 bits wide when WIDE is 1. An advance from all-ones gives zero and is an overflow event.
- R2: The divide code is {control[14:13], control[9]}. The count advances once per 2^code selected ticks, so code 0 gives one advance per tick.
- R3: Control bit 8 selects the tick source: 0 selects `sys_tick` and 1 selects `evt_tick`. The unselected strobe has no effect on the count.
- R4: A write to the control word (bus address 1) blocks counting in its own cycle. In the following cycle it clears the count and the divider, sets bit 10 to 1, and re-arms one-shot mode.
- R5: With control bits 4 and 5 both clear, the count holds its value.
- R6: An advance that makes the count equal the compare value (address 2) sets sticky bit 11. With control bit 3 set, the next advance after the count equals the compare value returns the count to zero.
- R7: An overflow event sets sticky bit 12.
- R8: A bus read of the control word returns bits 11 and 12 and clears them. An event in that same cycle keeps its bit set.
- R9: Bit 10 is active low and `irq` equals its inverse. It starts at 1 after reset. In pulse mode (bit 7 clear), a firing event drives bit 10 to 0 for exactly one clock. A firing event is a compare event with bit 4 set, or an overflow event with bit 5 set.
- R10: In toggle mode (bit 7 set), each firing event inverts bit 10, and bit 10 holds between events.
- R11: With repeat (bit 6) clear, only the first firing event after a control write drives the interrupt. Later events still set the sticky bits.
- R12: Write data on control bits 10, 11 and 12 is ignored.
- R13: With bit 0 set and bits 2:1 equal to 0, the count pauses while `gate` is 1. The other values of bits 2:1 count freely.
- R14: A bus write to address 0 loads the count. The load takes precedence over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 count, 1 control, 2 compare |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on control reads) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_tick | input | 1 | System tick strobe |
| evt_tick | input | 1 | External event tick strobe |
| gate | input | 1 | Pause input used by the gated sync mode |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two functions can fall in the same cycle: a read of the control word clears the sticky flags, and a count overflow sets bit 12. The bench loads the count just below all-ones. It then places the control read so that its strobe covers the exact edge where the wrap occurs. The rule is judged by reading the control word twice more: bit 12 must read as set once, with bit 10 low, and clear on the following read. A count load landing on an edge where the counter would also advance is judged the same way: the loaded value must be read back unchanged.

// File: rtl/prescaled_timer_pkg.sv
package prescaled_timer_pkg;

    localparam int CTRL_W     = 16;
    localparam int PSC_CODE_W = 3;

    // control word bit positions
    localparam int B_SYNC_ON  = 0;
    localparam int B_SYNC_LO  = 1;
    localparam int B_SYNC_HI  = 2;
    localparam int B_TGT_ZERO = 3;
    localparam int B_EN_TGT   = 4;
    localparam int B_EN_OVF   = 5;
    localparam int B_REPEAT   = 6;
    localparam int B_TOGGLE   = 7;
    localparam int B_SRC      = 8;
    localparam int B_PSC_LO   = 9;
    localparam int B_IRQ_N    = 10;
    localparam int B_SEEN_TGT = 11;
    localparam int B_SEEN_OVF = 12;
    localparam int B_PSC_HI0  = 13;
    localparam int B_PSC_HI1  = 14;

    localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 16'hE3FF;

    localparam logic [1:0] A_COUNT   = 2'd0;
    localparam logic [1:0] A_CTRL    = 2'd1;
    localparam logic [1:0] A_COMPARE = 2'd2;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int PSC_CODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  src_evt,
    input  logic                  sys_tick,
    input  logic                  evt_tick,
    input  logic                  run,
    input  logic [PSC_CODE_W-1:0] psc_code,
    output logic                  adv
);
    localparam int PSC_W = (1 << PSC_CODE_W) - 1;

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic             tick;
    logic [PSC_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        tick = src_evt ? evt_tick : sys_tick;
        lim  = PSC_W'((32'd1 << psc_code) - 32'd1);
        adv  = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick && run) begin
            if (st_q.cnt >= lim) begin
                st_d.cnt = '0;
                adv      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5 / R13: divider frozen while the unit is not running
    a_r13_divider_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(st_q.cnt));

    // R4: restart empties the divider
    a_r4_divider_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] target,
    input  logic             tgt_zero,
    output logic [CNT_W-1:0] count,
    output logic             tgt_evt,
    output logic             ovf_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tgt_evt = 1'b0;
        ovf_evt = 1'b0;
        if (ld) begin
            st_d.val = ld_val;
        end else if (restart) begin
            st_d.val = '0;
        end else if (adv) begin
            if (tgt_zero && (st_q.val == target)) begin
                st_d.val = '0;
            end else begin
                st_d.val = st_q.val + 1'b1;
                ovf_evt  = (st_q.val == {CNT_W{1'b1}});
                tgt_evt  = (st_d.val == target);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.val;

    // R14: a load is taken as written
    a_r14_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (count == $past(ld_val)));

    // R4: restart leaves the count at zero
    a_r4_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !ld) |=> (count == '0));

    // R5: nothing moves the count without a cause
    a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !ld && !restart) |=> $stable(count));

    // R1: an overflow always lands on zero
    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (count == '0));

endmodule

// File: rtl/timer_status.sv
module timer_status (
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    input  logic tgt_evt,
    input  logic ovf_evt,
    input  logic en_tgt,
    input  logic en_ovf,
    input  logic repeat_en,
    input  logic toggle_en,
    input  logic rd_clr,
    output logic irq_n,
    output logic seen_tgt,
    output logic seen_ovf
);
    typedef struct packed {
        logic irq_n;
        logic seen_tgt;
        logic seen_ovf;
        logic fired;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d          = st_q;
        fire          = ((tgt_evt && en_tgt) || (ovf_evt && en_ovf)) &&
                        (repeat_en || !st_q.fired);
        st_d.seen_tgt = (st_q.seen_tgt && !rd_clr) || tgt_evt;
        st_d.seen_ovf = (st_q.seen_ovf && !rd_clr) || ovf_evt;
        if (rearm) begin
            st_d.fired = 1'b0;
            st_d.irq_n = 1'b1;
        end else if (fire) begin
            st_d.fired = 1'b1;
            st_d.irq_n = toggle_en ? ~st_q.irq_n : 1'b0;
        end else if (!toggle_en) begin
            st_d.irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{irq_n: 1'b1, seen_tgt: 1'b0, seen_ovf: 1'b0, fired: 1'b0};
        else        st_q <= st_d;
    end

    assign irq_n    = st_q.irq_n;
    assign seen_tgt = st_q.seen_tgt;
    assign seen_ovf = st_q.seen_ovf;

    // R7: overflow is recorded
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> seen_ovf);

    // R8: a read without a new event empties both flags
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !tgt_evt && !ovf_evt) |=> (!seen_tgt && !seen_ovf));

    // R9: pulse mode low level lasts one clock
    a_r9_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_en && !irq_n && !tgt_evt && !ovf_evt) |=> irq_n);

    // R10: toggle level holds between events
    a_r10_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_en && !rearm && !tgt_evt && !ovf_evt) |=> $stable(irq_n));

    // R11: one-shot stays quiet after its first firing
    a_r11_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fired && !repeat_en && !toggle_en && !rearm && irq_n) |=> irq_n);

endmodule

// File: rtl/prescaled_irq_timer.sv
module prescaled_irq_timer
    import prescaled_timer_pkg::*;
#(
    parameter bit WIDE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        sys_tick,
    input  logic        evt_tick,
    input  logic        gate,
    output logic        irq
);
    localparam int CNT_W = WIDE ? 32 : 16;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  target;
        logic              restart;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                  ctrl_wr, cnt_ld, rd_clr, paused, run, adv;
    logic                  tgt_evt, ovf_evt, irq_n, seen_tgt, seen_ovf;
    logic [PSC_CODE_W-1:0] psc_code;
    logic [CNT_W-1:0]      count;
    logic [CTRL_W-1:0]     ctrl_view;

    always_comb begin
        st_d         = st_q;
        ctrl_wr      = bus_wr && (bus_addr == A_CTRL);
        cnt_ld       = bus_wr && (bus_addr == A_COUNT);
        rd_clr       = bus_rd && (bus_addr == A_CTRL);
        st_d.restart = ctrl_wr;
        if (ctrl_wr)
            st_d.ctrl = bus_wdata[CTRL_W-1:0] & CTRL_WR_MASK;
        if (bus_wr && (bus_addr == A_COMPARE))
            st_d.target = bus_wdata[CNT_W-1:0];

        psc_code = {st_q.ctrl[B_PSC_HI1], st_q.ctrl[B_PSC_HI0], st_q.ctrl[B_PSC_LO]};
        paused   = st_q.ctrl[B_SYNC_ON] && !st_q.ctrl[B_SYNC_LO] &&
                   !st_q.ctrl[B_SYNC_HI] && gate;
        run      = (st_q.ctrl[B_EN_TGT] || st_q.ctrl[B_EN_OVF]) && !paused && !ctrl_wr;

        ctrl_view             = st_q.ctrl;
        ctrl_view[B_IRQ_N]    = irq_n;
        ctrl_view[B_SEEN_TGT] = seen_tgt;
        ctrl_view[B_SEEN_OVF] = seen_ovf;

        case (bus_addr)
            A_COUNT:   bus_rdata = 32'(count);
            A_CTRL:    bus_rdata = 32'(ctrl_view);
            A_COMPARE: bus_rdata = 32'(st_q.target);
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    timer_prescaler #(.PSC_CODE_W(PSC_CODE_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (st_q.restart),
        .src_evt  (st_q.ctrl[B_SRC]),
        .sys_tick (sys_tick),
        .evt_tick (evt_tick),
        .run      (run),
        .psc_code (psc_code),
        .adv      (adv)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (st_q.restart),
        .adv      (adv),
        .ld       (cnt_ld),
        .ld_val   (bus_wdata[CNT_W-1:0]),
        .target   (st_q.target),
        .tgt_zero (st_q.ctrl[B_TGT_ZERO]),
        .count    (count),
        .tgt_evt  (tgt_evt),
        .ovf_evt  (ovf_evt)
    );

    timer_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rearm     (ctrl_wr),
        .tgt_evt   (tgt_evt),
        .ovf_evt   (ovf_evt),
        .en_tgt    (st_q.ctrl[B_EN_TGT]),
        .en_ovf    (st_q.ctrl[B_EN_OVF]),
        .repeat_en (st_q.ctrl[B_REPEAT]),
        .toggle_en (st_q.ctrl[B_TOGGLE]),
        .rd_clr    (rd_clr),
        .irq_n     (irq_n),
        .seen_tgt  (seen_tgt),
        .seen_ovf  (seen_ovf)
    );

    assign irq = ~irq_n;

    // R4: a control write arms the restart for the next cycle
    a_r4_restart_armed: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> st_q.restart);

    // R4: the write cycle itself never advances the count
    a_r4_no_adv_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |-> !adv);

    // R12: status bits of the stored control word never come from write data
    a_r12_status_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (st_q.ctrl[B_SEEN_OVF:B_IRQ_N] == 3'b000));

endmodule

// File: tb/prescaled_irq_timer_tb_top.sv
module prescaled_irq_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        sys_tick = 1'b1;
    logic        evt_tick = 1'b0;
    logic        gate = 1'b0;
    logic [31:0] rdata16, rdata32;
    logic        irq16, irq32;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    prescaled_irq_timer #(.WIDE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata16),
        .sys_tick(sys_tick), .evt_tick(evt_tick), .gate(gate), .irq(irq16));

    prescaled_irq_timer #(.WIDE(1'b1)) dut_w (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata32),
        .sys_tick(sys_tick), .evt_tick(evt_tick), .gate(gate), .irq(irq32));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // called at a falling edge; samples now, strobe spans the next rising edge
    task automatic rd(input logic [1:0] a, output logic [31:0] v16, output logic [31:0] v32);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        v16 = rdata16; v32 = rdata32;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        rd(2'd0, a, b); chk("R4 reset count", a, 32'h0);
        rd(2'd1, a, b); chk("R9 reset control", a, 32'h0400);
        chk("R9 reset irq", {31'b0, irq16}, 32'h0);
    endtask

    task automatic t_hold;
        logic [31:0] a, b;
        wr(2'd1, 32'h0000);
        wr(2'd0, 32'd5);
        repeat (8) @(negedge clk);
        rd(2'd0, a, b); chk("R5 count holds with no enable", a, 32'd5);
    endtask

    task automatic t_count;
        logic [31:0] a, b;
        wr(2'd2, 32'd1000);
        wr(2'd1, 32'h0010);
        repeat (10) @(negedge clk);
        rd(2'd0, a, b); chk("R2 divide-by-1 count", a, 32'd9);
        wr(2'd0, 32'd100);
        rd(2'd0, a, b); chk("R14 load beats advance", a, 32'd100);
        wr(2'd1, 32'h0010);
        @(negedge clk);
        rd(2'd0, a, b); chk("R4 restart clears count", a, 32'd0);
    endtask

    task automatic t_psc;
        logic [31:0] a, b;
        wr(2'd1, 32'h2010);
        repeat (10) @(negedge clk);
        rd(2'd0, a, b); chk("R2 divide-by-4", a, 32'd2);
        wr(2'd1, 32'h0210);
        repeat (10) @(negedge clk);
        rd(2'd0, a, b); chk("R2 divide-by-2", a, 32'd4);
    endtask

    task automatic t_src;
        logic [31:0] a, b;
        wr(2'd1, 32'h0110);
        repeat (6) @(negedge clk);
        rd(2'd0, a, b); chk("R3 system tick ignored", a, 32'd0);
        for (int i = 0; i < 3; i++) begin
            evt_tick = 1'b1; @(negedge clk);
            evt_tick = 1'b0; @(negedge clk);
        end
        rd(2'd0, a, b); chk("R3 event ticks counted", a, 32'd3);
    endtask

    task automatic t_gate;
        logic [31:0] a, b;
        gate = 1'b1;
        wr(2'd1, 32'h0011);
        repeat (6) @(negedge clk);
        rd(2'd0, a, b); chk("R13 gate pauses", a, 32'd0);
        gate = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd0, a, b); chk("R13 gate released", a, 32'd5);
        gate = 1'b1;
        wr(2'd1, 32'h0013);
        repeat (10) @(negedge clk);
        rd(2'd0, a, b); chk("R13 other sync mode free-runs", a, 32'd9);
        gate = 1'b0;
    endtask

    task automatic irq_window(input logic [31:0] ctrl, input string req, input int exp);
        int hits = 0;
        wr(2'd1, ctrl);
        repeat (20) begin
            @(negedge clk);
            if (irq16) hits++;
        end
        chk(req, hits, exp);
    endtask

    task automatic t_target;
        logic [31:0] a, b;
        wr(2'd2, 32'd3);
        irq_window(32'h0058, "R6 R9 repeat pulses on target", 5);
        rd(2'd1, a, b); chk("R6 target flag set", (a >> 11) & 1, 32'd1);
        irq_window(32'h0018, "R11 one-shot fires once", 1);
        rd(2'd1, a, b); chk("R11 flag still set after one-shot", (a >> 11) & 1, 32'd1);
        irq_window(32'h00D8, "R10 toggle level", 9);
    endtask

    task automatic t_ovf;
        logic [31:0] a, b;
        wr(2'd2, 32'h8000);
        wr(2'd1, 32'h0020);
        wr(2'd0, 32'hFFFD);
        repeat (2) @(negedge clk);
        chk("R9 no irq before overflow", {31'b0, irq16}, 32'h0);
        rd(2'd1, a, b); chk("R7 flag clear before overflow", (a >> 12) & 1, 32'd0);
        chk("R9 overflow pulse", {31'b0, irq16}, 32'h1);
        rd(2'd1, a, b);
        chk("R8 set wins over read clear", (a >> 12) & 1, 32'd1);
        chk("R9 bit10 low during pulse", (a >> 10) & 1, 32'd0);
        rd(2'd1, a, b);
        chk("R8 read clears overflow flag", (a >> 12) & 1, 32'd0);
        chk("R9 bit10 back high", (a >> 10) & 1, 32'd1);
    endtask

    task automatic t_wide;
        logic [31:0] a, b;
        wr(2'd1, 32'h0020);
        wr(2'd0, 32'h0000FFFF);
        @(negedge clk);
        chk("R1 narrow wraps at 16 bits", {31'b0, irq16}, 32'h1);
        chk("R1 wide does not wrap at 16 bits", {31'b0, irq32}, 32'h0);
        rd(2'd0, a, b);
        chk("R1 narrow count after wrap", a, 32'h0);
        chk("R1 wide count passes 0xFFFF", b, 32'h00010000);
        wr(2'd0, 32'hFFFFFFFE);
        @(negedge clk);
        chk("R1 wide no irq at all-ones", {31'b0, irq32}, 32'h0);
        @(negedge clk);
        chk("R1 wide overflow irq", {31'b0, irq32}, 32'h1);
    endtask

    task automatic t_mask;
        logic [31:0] a, b;
        wr(2'd1, 32'h0000);
        @(negedge clk);
        rd(2'd1, a, b);
        wr(2'd1, 32'h1D00);
        rd(2'd1, a, b); chk("R12 status write data ignored", a, 32'h0500);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_count();
        t_psc();
        t_src();
        t_gate();
        t_target();
        t_ovf();
        t_wide();
        t_mask();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule